// File: doc/BRIEF.md
# Result-Latency and Unit-Occupancy Hazard Scoreboard

This block sits in the issue stage of an in-order pipeline in which each functional unit accepts at most one instruction per cycle. For every architectural register it keeps a countdown of the cycles left before a result still in flight can be read. For every functional unit it keeps a countdown of the cycles left before the unit can take new work. An instruction presented at the input is held back (stall) while any register it reads or writes is still pending, or while the unit it targets is still occupied. In every other case it is accepted in the same cycle (issue).

The result latency (delay slots) and the unit occupancy are separate figures that depend on the operation class. Single-cycle operations have no delay slots and free their unit after one cycle. Single-precision multiply and add operations have three delay slots and also free their unit after one cycle. Double-precision multiply operations have nine delay slots and hold their unit for four cycles. A double-precision operation writes and reads register pairs: the even register and the odd register that follows it.

Top module: `latency_scoreboard`

## Requirements
- R1: After reset every register and every unit is free. With `in_valid` low both `stall` and `issue` are 0, and the first valid instruction issues in the cycle it is presented.
- R2: `issue` equals `in_valid` and not `stall`. `stall` is never 1 while `in_valid` is 0.
- R3: A class-0 (single-cycle) result can be read by an instruction presented in the very next cycle, with no stall.
- R4: After a class-1 (single-precision multiply/add) instruction issues, an instruction that reads its destination stalls for 3 cycles when presented in the next cycle.
- R5: After a class-2 (double-precision multiply) instruction issues, a reader of its destination stalls for 9 cycles when presented in the next cycle. Idle cycles count down the same wait, so a reader presented after 5 idle cycles stalls for 4.
- R6: A class-2 instruction holds its unit for 4 cycles, so the next instruction on that unit stalls 3 cycles. Class-0 and class-1 instructions free their unit for the next cycle.
- R7: An occupied unit does not block an instruction that targets a different unit.
- R8: A class-2 destination marks both registers of its pair (index with bit 0 cleared, and with bit 0 set) as pending, whichever of the two indices is given. A class-2 source reads both registers of its pair.
- R9: An instruction whose destination register is still pending stalls until that register is free, even when it reads nothing.
- R10: A source or destination whose enable bit is 0 is not checked and does not cause a stall. A destination whose enable bit is 0 marks nothing as pending.
- R11: Class code 3 behaves as a single-cycle class: no delay slots and one cycle of unit occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented |
| in_class | input | 2 | Operation class: 0 single-cycle, 1 single-precision multiply/add, 2 double-precision multiply, 3 single-cycle |
| in_unit | input | 3 | Target functional unit index |
| in_src_a | input | 5 | First source register index |
| in_src_a_en | input | 1 | First source is read |
| in_src_b | input | 5 | Second source register index |
| in_src_b_en | input | 1 | Second source is read |
| in_dst | input | 5 | Destination register index |
| in_dst_en | input | 1 | Destination is written |
| stall | output | 1 | Presented instruction must wait |
| issue | output | 1 | Presented instruction is accepted this cycle |

## Verification
The bench builds the block with its default parameters: 32 registers, 8 units, 3 single-precision delay slots, 9 double-precision delay slots and 4 cycles of double-precision occupancy. These values make the full 9-cycle result wait, and the 4-cycle unit hold that ends before it, both visible as exact stall counts. With 32 registers, several independent pairs and units can be exercised without interference. Stall counts are measured cycle by cycle from the cycle after the producer issues, so an error of one cycle in either countdown, or a missing pair partner, shows up as a count mismatch.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    OPC_SINGLE = 2'd0,
    OPC_SPMA   = 2'd1,
    OPC_DPMUL  = 2'd2,
    OPC_AUX    = 2'd3
  } op_class_e;
endpackage

// File: rtl/sb_latency_decode.sv
module sb_latency_decode #(
  parameter int DLY_SP = 3,
  parameter int DLY_DP = 9,
  parameter int OCC_DP = 4,
  parameter int CNT_W  = 4
) (
  input  logic [1:0]       op_class,
  output logic [CNT_W-1:0] result_wait,
  output logic [CNT_W-1:0] unit_hold,
  output logic             pair_mode
);
  import sb_pkg::*;

  localparam logic [CNT_W-1:0] W_SP  = CNT_W'(DLY_SP);
  localparam logic [CNT_W-1:0] W_DP  = CNT_W'(DLY_DP);
  localparam logic [CNT_W-1:0] H_DP  = CNT_W'(OCC_DP - 1);

  always_comb begin
    result_wait = '0;
    unit_hold   = '0;
    pair_mode   = 1'b0;
    unique case (op_class_e'(op_class))
      OPC_SPMA: begin
        result_wait = W_SP;
      end
      OPC_DPMUL: begin
        result_wait = W_DP;
        unit_hold   = H_DP;
        pair_mode   = 1'b1;
      end
      default: begin
        result_wait = '0;
      end
    endcase
  end
endmodule

// File: rtl/sb_countdown_bank.sv
module sb_countdown_bank #(
  parameter int N       = 32,
  parameter int CNT_W   = 4,
  parameter int MAX_VAL = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     load_mask,
  input  logic [CNT_W-1:0] load_val,
  output logic [N-1:0]     busy
);
  logic [CNT_W-1:0] cnt_q [N];
  logic [CNT_W-1:0] cnt_d [N];
  logic [N-1:0]     cnt_en;

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_comb begin
      cnt_en[i] = load_mask[i] || (cnt_q[i] != '0);
      if (load_mask[i]) begin
        cnt_d[i] = load_val;
      end else if (cnt_q[i] != '0) begin
        cnt_d[i] = cnt_q[i] - 1'b1;
      end else begin
        cnt_d[i] = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[i] <= '0;
      end else if (cnt_en[i]) begin
        cnt_q[i] <= cnt_d[i];
      end
    end

    assign busy[i] = (cnt_q[i] != '0);

    // a slot is only reloaded once it has drained (R9, R6)
    assert_slot_free_at_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_mask[i] |-> (cnt_q[i] == '0));

    // a pending slot moves down by exactly one per cycle (R4)
    assert_slot_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_q[i] != '0) && !load_mask[i]) |=> (cnt_q[i] == $past(cnt_q[i]) - 1'b1));

    // no count exceeds the longest latency (R5)
    assert_slot_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cnt_q[i]) <= MAX_VAL));
  end
endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check #(
  parameter int NREG   = 32,
  parameter int NUNIT  = 8,
  parameter int REG_W  = 5,
  parameter int UNIT_W = 3
) (
  input  logic              in_valid,
  input  logic              pair_mode,
  input  logic [UNIT_W-1:0] in_unit,
  input  logic [REG_W-1:0]  in_src_a,
  input  logic              in_src_a_en,
  input  logic [REG_W-1:0]  in_src_b,
  input  logic              in_src_b_en,
  input  logic [REG_W-1:0]  in_dst,
  input  logic              in_dst_en,
  input  logic [NREG-1:0]   reg_busy,
  input  logic [NUNIT-1:0]  unit_busy,
  output logic              stall,
  output logic              issue,
  output logic [NREG-1:0]   reg_load,
  output logic [NUNIT-1:0]  unit_load
);
  logic [REG_W-1:0] a_even, a_odd, b_even, b_odd, d_even, d_odd;
  logic a_pend, b_pend, d_pend, u_pend, hazard;

  always_comb begin
    a_even = {in_src_a[REG_W-1:1], 1'b0};
    a_odd  = {in_src_a[REG_W-1:1], 1'b1};
    b_even = {in_src_b[REG_W-1:1], 1'b0};
    b_odd  = {in_src_b[REG_W-1:1], 1'b1};
    d_even = {in_dst[REG_W-1:1], 1'b0};
    d_odd  = {in_dst[REG_W-1:1], 1'b1};

    if (pair_mode) begin
      a_pend = in_src_a_en && (reg_busy[a_even] || reg_busy[a_odd]);
      b_pend = in_src_b_en && (reg_busy[b_even] || reg_busy[b_odd]);
      d_pend = in_dst_en   && (reg_busy[d_even] || reg_busy[d_odd]);
    end else begin
      a_pend = in_src_a_en && reg_busy[in_src_a];
      b_pend = in_src_b_en && reg_busy[in_src_b];
      d_pend = in_dst_en   && reg_busy[in_dst];
    end
    u_pend = unit_busy[in_unit];

    hazard = a_pend || b_pend || d_pend || u_pend;
    stall  = in_valid && hazard;
    issue  = in_valid && !hazard;

    reg_load = '0;
    if (issue && in_dst_en) begin
      if (pair_mode) begin
        reg_load[d_even] = 1'b1;
        reg_load[d_odd]  = 1'b1;
      end else begin
        reg_load[in_dst] = 1'b1;
      end
    end

    unit_load = '0;
    if (issue) begin
      unit_load[in_unit] = 1'b1;
    end
  end
endmodule

// File: rtl/latency_scoreboard.sv
module latency_scoreboard #(
  parameter int NREG   = 32,
  parameter int NUNIT  = 8,
  parameter int DLY_SP = 3,
  parameter int DLY_DP = 9,
  parameter int OCC_DP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               in_class,
  input  logic [$clog2(NUNIT)-1:0] in_unit,
  input  logic [$clog2(NREG)-1:0]  in_src_a,
  input  logic                     in_src_a_en,
  input  logic [$clog2(NREG)-1:0]  in_src_b,
  input  logic                     in_src_b_en,
  input  logic [$clog2(NREG)-1:0]  in_dst,
  input  logic                     in_dst_en,
  output logic                     stall,
  output logic                     issue
);
  localparam int REG_W  = $clog2(NREG);
  localparam int UNIT_W = $clog2(NUNIT);
  localparam int MAXLAT = (DLY_DP > DLY_SP) ? DLY_DP : DLY_SP;
  localparam int CNT_W  = $clog2(MAXLAT + 1);

  logic [CNT_W-1:0] result_wait, unit_hold;
  logic             pair_mode;
  logic [NREG-1:0]  reg_busy, reg_load;
  logic [NUNIT-1:0] unit_busy, unit_load;

  sb_latency_decode #(
    .DLY_SP(DLY_SP), .DLY_DP(DLY_DP), .OCC_DP(OCC_DP), .CNT_W(CNT_W)
  ) u_decode (
    .op_class(in_class), .result_wait(result_wait),
    .unit_hold(unit_hold), .pair_mode(pair_mode)
  );

  sb_hazard_check #(
    .NREG(NREG), .NUNIT(NUNIT), .REG_W(REG_W), .UNIT_W(UNIT_W)
  ) u_check (
    .in_valid(in_valid), .pair_mode(pair_mode), .in_unit(in_unit),
    .in_src_a(in_src_a), .in_src_a_en(in_src_a_en),
    .in_src_b(in_src_b), .in_src_b_en(in_src_b_en),
    .in_dst(in_dst), .in_dst_en(in_dst_en),
    .reg_busy(reg_busy), .unit_busy(unit_busy),
    .stall(stall), .issue(issue),
    .reg_load(reg_load), .unit_load(unit_load)
  );

  sb_countdown_bank #(
    .N(NREG), .CNT_W(CNT_W), .MAX_VAL(MAXLAT)
  ) u_reg_bank (
    .clk(clk), .rst_n(rst_n), .load_mask(reg_load),
    .load_val(result_wait), .busy(reg_busy)
  );

  sb_countdown_bank #(
    .N(NUNIT), .CNT_W(CNT_W), .MAX_VAL(MAXLAT)
  ) u_unit_bank (
    .clk(clk), .rst_n(rst_n), .load_mask(unit_load),
    .load_val(unit_hold), .busy(unit_busy)
  );

  // accept and hold back are mutually exclusive (R2)
  assert_issue_not_stalled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !stall);

  // nothing happens without a presented instruction (R2)
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!stall && !issue));

  // a target unit is free whenever an instruction is accepted (R6)
  assert_unit_free_at_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !unit_busy[in_unit]);

  // a double-precision write leaves both pair halves pending (R8)
  assert_pair_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && in_dst_en && (in_class == 2'd2) && (DLY_DP != 0)) |=>
      (reg_busy[{$past(in_dst[REG_W-1:1]), 1'b0}] && reg_busy[{$past(in_dst[REG_W-1:1]), 1'b1}]));
endmodule

// File: tb/latency_scoreboard_bench.sv
module latency_scoreboard_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_class = 2'd0;
  logic [2:0] in_unit = 3'd0;
  logic [4:0] in_src_a = 5'd0, in_src_b = 5'd0, in_dst = 5'd0;
  logic       in_src_a_en = 1'b0, in_src_b_en = 1'b0, in_dst_en = 1'b0;
  logic       stall, issue;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latency_scoreboard u_latency_scoreboard (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_unit(in_unit), .in_src_a(in_src_a), .in_src_a_en(in_src_a_en),
    .in_src_b(in_src_b), .in_src_b_en(in_src_b_en), .in_dst(in_dst),
    .in_dst_en(in_dst_en), .stall(stall), .issue(issue)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // present an instruction just after a falling edge, count stall cycles
  // until it is accepted, compare with the expected count
  task automatic send(input logic [1:0] cls, input logic [2:0] unit,
                      input logic [4:0] sa, input logic sae,
                      input logic [4:0] sb, input logic sbe,
                      input logic [4:0] d, input logic de,
                      input int exp_stalls, input string req);
    int n = 0;
    in_valid = 1'b1; in_class = cls; in_unit = unit;
    in_src_a = sa; in_src_a_en = sae; in_src_b = sb; in_src_b_en = sbe;
    in_dst = d; in_dst_en = de;
    #1;
    while (!issue && n < 40) begin
      if (stall !== 1'b1) check(1'b0, "R2", int'(stall), 1);
      n++;
      @(negedge clk);
      #1;
    end
    check(n == exp_stalls, req, n, exp_stalls);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int cycles);
    in_valid = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    check(stall == 1'b0 && issue == 1'b0, "R1", int'({stall, issue}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(stall == 1'b0 && issue == 1'b0, "R2", int'({stall, issue}), 0);
    // first instruction after reset, reading and writing anything
    send(2'd1, 3'd0, 5'd3, 1'b1, 5'd9, 1'b1, 5'd2, 1'b1, 0, "R1");
    idle(12);
  endtask

  task automatic t_single;
    send(2'd0, 3'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd1, 1'b1, 0, "R3");
    send(2'd0, 3'd0, 5'd1, 1'b1, 5'd0, 1'b0, 5'd5, 1'b1, 0, "R3");
    // same unit again straight after a single-cycle op
    send(2'd0, 3'd0, 5'd5, 1'b1, 5'd0, 1'b0, 5'd8, 1'b1, 0, "R6");
    idle(2);
  endtask

  task automatic t_sp;
    send(2'd1, 3'd2, 5'd0, 1'b0, 5'd0, 1'b0, 5'd4, 1'b1, 0, "R4");
    send(2'd0, 3'd3, 5'd11, 1'b0, 5'd4, 1'b1, 5'd13, 1'b1, 3, "R4");
    // class 1 frees its unit at once
    send(2'd1, 3'd2, 5'd0, 1'b0, 5'd0, 1'b0, 5'd14, 1'b1, 0, "R6");
    send(2'd1, 3'd2, 5'd0, 1'b0, 5'd0, 1'b0, 5'd18, 1'b1, 0, "R6");
    idle(12);
  endtask

  task automatic t_dp;
    send(2'd2, 3'd1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd6, 1'b1, 0, "R5");
    // odd half of the pair, different unit
    send(2'd0, 3'd5, 5'd7, 1'b1, 5'd0, 1'b0, 5'd19, 1'b1, 9, "R8");
    send(2'd2, 3'd1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd10, 1'b1, 0, "R6");
    send(2'd1, 3'd1, 5'd21, 1'b1, 5'd22, 1'b1, 5'd20, 1'b1, 3, "R6");
    send(2'd2, 3'd1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd12, 1'b1, 0, "R7");
    send(2'd0, 3'd2, 5'd0, 1'b0, 5'd0, 1'b0, 5'd23, 1'b1, 0, "R7");
    idle(12);
  endtask

  task automatic t_idle_countdown;
    send(2'd2, 3'd6, 5'd0, 1'b0, 5'd0, 1'b0, 5'd24, 1'b1, 0, "R5");
    idle(5);
    send(2'd0, 3'd6, 5'd24, 1'b1, 5'd0, 1'b0, 5'd29, 1'b1, 4, "R5");
    idle(12);
  endtask

  task automatic t_pair_dst;
    // odd index given, even half must be pending too
    send(2'd2, 3'd4, 5'd0, 1'b0, 5'd0, 1'b0, 5'd27, 1'b1, 0, "R8");
    send(2'd0, 3'd0, 5'd26, 1'b1, 5'd0, 1'b0, 5'd28, 1'b1, 9, "R8");
    // pair source: reading r2 as a pair sees a pending r3
    send(2'd1, 3'd3, 5'd0, 1'b0, 5'd0, 1'b0, 5'd3, 1'b1, 0, "R8");
    send(2'd2, 3'd4, 5'd2, 1'b1, 5'd0, 1'b0, 5'd30, 1'b1, 3, "R8");
    idle(12);
  endtask

  task automatic t_waw;
    send(2'd1, 3'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd15, 1'b1, 0, "R9");
    send(2'd0, 3'd4, 5'd0, 1'b0, 5'd0, 1'b0, 5'd15, 1'b1, 3, "R9");
    idle(4);
  endtask

  task automatic t_enables;
    send(2'd1, 3'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd16, 1'b1, 0, "R10");
    send(2'd0, 3'd5, 5'd16, 1'b0, 5'd16, 1'b0, 5'd17, 1'b1, 0, "R10");
    send(2'd0, 3'd5, 5'd16, 1'b1, 5'd0, 1'b0, 5'd9, 1'b1, 2, "R10");
    // disabled destination marks nothing
    send(2'd1, 3'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd21, 1'b0, 0, "R10");
    send(2'd0, 3'd5, 5'd21, 1'b1, 5'd0, 1'b0, 5'd22, 1'b1, 0, "R10");
    idle(4);
  endtask

  task automatic t_aux_class;
    send(2'd3, 3'd7, 5'd0, 1'b0, 5'd0, 1'b0, 5'd30, 1'b1, 0, "R11");
    send(2'd3, 3'd7, 5'd30, 1'b1, 5'd0, 1'b0, 5'd31, 1'b1, 0, "R11");
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_sp();
    t_dp();
    t_idle_countdown();
    t_pair_dst();
    t_waw();
    t_enables();
    t_aux_class();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule